// File: doc/BRIEF.md
# Resolver converter configuration port (serial slave)

This block is the configuration side of a resolver-to-digital converter. It acts as a serial slave on a four-wire bus that uses SPI mode 3. A synchronous system clock oversamples the bus: the bus clock, chip select, data in and the two mode pins all pass through a parameterised synchroniser. The port answers only while the mode pins select configuration. Under the other pin codes (position readout, velocity readout, reserved) it ignores all bus traffic.

Each chip-select frame carries one byte. A byte whose most significant bit is 1 names a register. A byte with that bit at 0 carries seven bits of write data for the register named last. To read, the host sends two frames. The first names the register. During the second, the host sends 0xFF and the register contents come back. The register file holds these entries:

- a row of threshold registers starting at 0x88
- an excitation-frequency word at 0x91
- a control byte at 0x92
- a soft-reset location at 0xF0
- a fault byte at 0xFF

The fault byte captures test inputs when a sample strobe falls. Control fields drive the resolution-select and loop-option outputs.

Top module: `cfgp_config_port`

## Requirements
- R1: After reset these registers read back with these values: control 0x7E, every threshold 0x00, excitation 0x28, fault 0x00. The error flag is low. The control outputs therefore show resolution code 2'b10 with hysteresis 1 and lock range 1.
- R2: Bus activity is ignored, and the data-out enable stays low, unless mode pin A0 is 1 and A1 is 0. A0/A1 = 0/0 (position), 0/1 (velocity) and 1/1 (reserved) all leave the registers and the error flag untouched.
- R3: A byte with bit 7 set is an address. A byte with bit 7 clear writes its bits [6:0] to the last addressed register. The address persists, so the next data byte without a new address overwrites the same register.
- R4: A read answers in the frame after the address frame. The reply is shifted out MSB first, and a new bit is launched on each falling bus-clock edge. Seven-bit registers read with bit 7 = 0, and the fault byte returns all 8 bits.
- R5: Threshold registers sit at 0x88 up to 0x88+NUM_THR-1 (0x8E by default). The excitation word is at 0x91 and the control byte at 0x92. All of them can be written and read back.
- R6: Reading an unmapped address, or 0xF0, returns 0x00 and raises no error. A data byte that follows an unmapped address or 0xFF changes no register and sets a sticky error flag. The flag clears only on reset.
- R7: A data byte that arrives before any address byte since reset is ignored and sets the sticky error flag.
- R8: A data byte that follows address 0xF0 produces a soft-reset pulse one clock long and clears the fault byte. All other registers keep their values.
- R9: On each falling edge of the sample strobe, the fault byte ORs in the fault inputs. If an address byte 0xFF has arrived since the previous falling edge, the fault byte is instead replaced by the inputs.
- R10: The control outputs change only on a control write. Resolution select is control bits [1:0], hysteresis is bit 4 and lock range is bit 5.
- R11: If chip select rises before eight bits have arrived, the partial byte is discarded and the held address is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a0 | input | 1 | Mode pin A0 |
| mode_a1 | input | 1 | Mode pin A1 |
| spi_sclk | input | 1 | Bus clock, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| sample_n | input | 1 | Sample strobe; falling edge latches faults |
| fault_in | input | 8 | Fault flags from the test environment |
| res_sel_o | output | 2 | Resolution code from control bits [1:0] |
| hyst_en_o | output | 1 | Hysteresis enable, control bit 4 |
| lock_range_o | output | 1 | Phase-lock range select, control bit 5 |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the port with its defaults: two synchroniser stages, seven thresholds and excitation reset 0x28. With these values the full threshold row up to 0x8E is mapped and 0x90 becomes an unmapped hole just before the excitation word. The bus half-period of eight system clocks leaves enough slack for the two-stage synchroniser and edge detector. Every bus edge is therefore seen, and MISO has settled before the host samples it. This makes the two-frame read, partial-frame abort and mode gating observable cycle by cycle against the bench's own register model.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam logic [7:0] ADR_THR_BASE = 8'h88;
   localparam logic [7:0] ADR_EXCIT    = 8'h91;
   localparam logic [7:0] ADR_CTRL     = 8'h92;
   localparam logic [7:0] ADR_SRST     = 8'hF0;
   localparam logic [7:0] ADR_FAULT    = 8'hFF;
   localparam logic [6:0] CTRL_RST     = 7'h7E;

   // pin code packed as {A1, A0}
   typedef enum logic [1:0] {
      PM_POS = 2'b00,
      PM_CFG = 2'b01,
      PM_VEL = 2'b10,
      PM_RSV = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_thru
         assign q = d;
      end else begin : g_ff
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          sclk,
   input  logic          mosi,
   input  logic          tx_load,
   input  logic [DW-1:0] tx_data,
   output logic          byte_vld,
   output logic [DW-1:0] byte_q,
   output logic          miso
);
   localparam int CW = $clog2(DW);
   localparam logic [CW-1:0] LAST = CW'(DW - 1);

   logic          sclk_p;
   logic          started;
   logic [CW-1:0] cnt;
   logic [DW-2:0] rx;
   logic [DW-1:0] tx;
   logic          rise, fall;

   assign rise = active &  sclk & ~sclk_p;
   assign fall = active & ~sclk &  sclk_p;
   assign miso = tx[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p   <= 1'b1;
         started  <= 1'b0;
         cnt      <= '0;
         rx       <= '0;
         tx       <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         sclk_p   <= sclk;
         byte_vld <= 1'b0;
         if (!active) begin
            cnt     <= '0;
            started <= 1'b0;
         end else if (rise) begin
            if (cnt == LAST) begin
               byte_vld <= 1'b1;
               byte_q   <= {rx, mosi};
               cnt      <= '0;
               started  <= 1'b0;
            end else begin
               rx      <= {rx[DW-3:0], mosi};
               cnt     <= cnt + 1'b1;
               started <= 1'b1;
            end
         end
         if (tx_load)
            tx <= tx_data;
         else if (fall && started)
            tx <= {tx[DW-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
   import cfgp_pkg::*;
#(
   parameter int         NUM_THR = 7,
   parameter logic [6:0] EXC_RST = 7'h28,
   parameter logic [6:0] THR_RST = 7'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   input  logic       sample_fall,
   input  logic [7:0] fault_in,
   output logic       tx_load,
   output logic [7:0] tx_data,
   output logic [6:0] ctrl_q,
   output logic [7:0] fault_q,
   output logic       wr_stb,
   output logic       soft_rst,
   output logic       proto_err
);
   localparam logic [7:0] THR_LAST = ADR_THR_BASE + 8'(NUM_THR - 1);

   logic [6:0] thr_q [NUM_THR];
   logic [6:0] exc_q;
   logic [7:0] addr_q;
   logic       addr_ok;
   logic       armed;
   logic       is_addr, is_data, srst_hit;
   logic       new_ok;
   logic [7:0] rd_val;

   assign is_addr  = byte_vld &  byte_in[7];
   assign is_data  = byte_vld & ~byte_in[7];
   assign wr_stb   = is_data & addr_ok;
   assign srst_hit = wr_stb & (addr_q == ADR_SRST);

   always_comb begin
      new_ok = (byte_in >= ADR_THR_BASE && byte_in <= THR_LAST) ||
               byte_in == ADR_EXCIT || byte_in == ADR_CTRL || byte_in == ADR_SRST;
      rd_val = '0;
      for (int i = 0; i < NUM_THR; i++)
         if (byte_in == ADR_THR_BASE + 8'(i)) rd_val = {1'b0, thr_q[i]};
      if (byte_in == ADR_EXCIT) rd_val = {1'b0, exc_q};
      if (byte_in == ADR_CTRL)  rd_val = {1'b0, ctrl_q};
      if (byte_in == ADR_FAULT) rd_val = fault_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_THR; i++) thr_q[i] <= THR_RST;
         exc_q     <= EXC_RST;
         ctrl_q    <= CTRL_RST;
         fault_q   <= '0;
         addr_q    <= '0;
         addr_ok   <= 1'b0;
         armed     <= 1'b0;
         tx_load   <= 1'b0;
         tx_data   <= '0;
         soft_rst  <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         tx_load  <= 1'b0;
         soft_rst <= 1'b0;
         if (sample_fall) begin
            fault_q <= armed ? fault_in : (fault_q | fault_in);
            armed   <= 1'b0;
         end
         if (is_addr) begin
            addr_q  <= byte_in;
            addr_ok <= new_ok;
            tx_load <= 1'b1;
            tx_data <= rd_val;
            if (byte_in == ADR_FAULT) armed <= 1'b1;
         end
         if (is_data && !addr_ok) proto_err <= 1'b1;
         if (wr_stb) begin
            for (int i = 0; i < NUM_THR; i++)
               if (addr_q == ADR_THR_BASE + 8'(i)) thr_q[i] <= byte_in[6:0];
            if (addr_q == ADR_EXCIT) exc_q  <= byte_in[6:0];
            if (addr_q == ADR_CTRL)  ctrl_q <= byte_in[6:0];
         end
         if (srst_hit) begin
            soft_rst <= 1'b1;
            fault_q  <= '0;
            armed    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cfgp_config_port.sv
module cfgp_config_port
   import cfgp_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_THR     = 7,
   parameter logic [6:0] EXC_RST     = 7'h28
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_a0,
   input  logic       mode_a1,
   input  logic       spi_sclk,
   input  logic       spi_cs_n,
   input  logic       spi_mosi,
   output logic       spi_miso,
   output logic       spi_miso_oe,
   input  logic       sample_n,
   input  logic [7:0] fault_in,
   output logic [1:0] res_sel_o,
   output logic       hyst_en_o,
   output logic       lock_range_o,
   output logic       soft_rst_o,
   output logic       proto_err_o
);
   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("SYNC_STAGES must lie in 0..4");
      if (NUM_THR < 1 || NUM_THR > 9)
         $error("NUM_THR must lie in 1..9 to stay below the excitation word");
   end

   localparam int NSIG = 6;
   // {a0, a1, sclk, cs_n, mosi, sample_n}
   localparam logic [NSIG-1:0] IDLE = 6'b00_11_0_1;

   logic [NSIG-1:0] pins_s;
   logic a0_s, a1_s, sclk_s, cs_s, mosi_s, smp_s, smp_p;
   logic cfg_act, sample_fall;
   logic byte_vld, tx_load, wr_stb;
   logic [7:0] byte_q, tx_data, fault_w;
   logic [6:0] ctrl_q;

   cfgp_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({mode_a0, mode_a1, spi_sclk, spi_cs_n, spi_mosi, sample_n}),
      .q(pins_s)
   );
   assign {a0_s, a1_s, sclk_s, cs_s, mosi_s, smp_s} = pins_s;

   assign cfg_act     = (pin_mode_e'({a1_s, a0_s}) == PM_CFG) && !cs_s;
   assign spi_miso_oe = cfg_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_p <= 1'b1;
      else        smp_p <= smp_s;
   end
   assign sample_fall = smp_p & ~smp_s;

   cfgp_shift #(.DW(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(cfg_act), .sclk(sclk_s), .mosi(mosi_s),
      .tx_load(tx_load), .tx_data(tx_data),
      .byte_vld(byte_vld), .byte_q(byte_q), .miso(spi_miso)
   );

   cfgp_regs #(.NUM_THR(NUM_THR), .EXC_RST(EXC_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_q),
      .sample_fall(sample_fall), .fault_in(fault_in),
      .tx_load(tx_load), .tx_data(tx_data), .ctrl_q(ctrl_q), .fault_q(fault_w),
      .wr_stb(wr_stb), .soft_rst(soft_rst_o), .proto_err(proto_err_o)
   );

   assign res_sel_o    = ctrl_q[1:0];
   assign hyst_en_o    = ctrl_q[4];
   assign lock_range_o = ctrl_q[5];
endmodule

// File: rtl/cfgp_config_port_chk.sv
module cfgp_config_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       soft_rst_o,
   input logic       proto_err_o,
   input logic [1:0] res_sel_o,
   input logic       hyst_en_o,
   input logic       lock_range_o,
   input logic       wr_stb,
   input logic       byte_vld,
   input logic       cfg_act,
   input logic       sample_fall,
   input logic [7:0] fault_w
);
   // R8
   soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |=> !soft_rst_o);

   // R8
   soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> (fault_w == 8'h00));

   // R6
   proto_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o);

   // R10
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable({res_sel_o, hyst_en_o, lock_range_o}));

   // R2
   idle_nobyte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_act |=> !byte_vld);

   // R9
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_fall && !wr_stb) |=> $stable(fault_w));
endmodule

bind cfgp_config_port cfgp_config_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst_o(soft_rst_o), .proto_err_o(proto_err_o),
   .res_sel_o(res_sel_o), .hyst_en_o(hyst_en_o), .lock_range_o(lock_range_o),
   .wr_stb(wr_stb), .byte_vld(byte_vld), .cfg_act(cfg_act),
   .sample_fall(sample_fall), .fault_w(fault_w)
);

// File: tb/cfgp_config_port_test.sv
`timescale 1ns/1ps
module cfgp_config_port_test;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_a0 = 1'b1, mode_a1 = 1'b0;
   logic       spi_sclk = 1'b1, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic       sample_n = 1'b1;
   logic [7:0] fault_in = 8'h00;
   logic       spi_miso, spi_miso_oe;
   logic [1:0] res_sel_o;
   logic       hyst_en_o, lock_range_o, soft_rst_o, proto_err_o;

   always #2.5 clk = ~clk;

   cfgp_config_port uut (
      .clk(clk), .rst_n(rst_n), .mode_a0(mode_a0), .mode_a1(mode_a1),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .sample_n(sample_n), .fault_in(fault_in),
      .res_sel_o(res_sel_o), .hyst_en_o(hyst_en_o), .lock_range_o(lock_range_o),
      .soft_rst_o(soft_rst_o), .proto_err_o(proto_err_o)
   );

   int checks = 0, fails = 0, srst_cnt = 0, m_srst = 0;
   bit quiet = 0, oe_seen = 0;

   // behavioural reference model
   int m_val [256];
   int m_fault, m_last;
   bit m_armed, m_err;

   function automatic bit m_writable(int a);
      return (a >= 'h88 && a <= 'h8E) || a == 'h91 || a == 'h92 || a == 'hF0;
   endfunction

   task automatic m_init();
      for (int i = 0; i < 256; i++) m_val[i] = 0;
      m_val['h91] = 'h28;
      m_val['h92] = 'h7E;
      m_fault = 0; m_armed = 0; m_err = 0; m_last = -1;
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
      end
   endtask

   always @(posedge clk) if (rst_n && soft_rst_o) srst_cnt++;

   // per-clock comparison of the static outputs against the model (R10, R6, R7)
   always @(negedge clk) begin
      if (quiet && rst_n) begin
         logic [4:0] got, exp;
         got = {res_sel_o, hyst_en_o, lock_range_o, proto_err_o};
         exp = {2'(m_val['h92]), 1'(m_val['h92] >> 4), 1'(m_val['h92] >> 5), m_err};
         checks++;
         if (got !== exp) begin
            fails++;
            $display("FAIL R10 per-clock outputs got=%b exp=%b", got, exp);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      quiet = 0;
      rst_n = 0;
      idle(6);
      m_init();
      rst_n = 1;
      idle(6);
      quiet = 1;
   endtask

   task automatic frame(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      bit cfg;
      rx = '0;
      quiet = 0;
      oe_seen = 0;
      spi_cs_n = 0;
      idle(HALF);
      for (int i = 7; i > 7 - nbits; i--) begin
         spi_sclk = 0;
         spi_mosi = tx[i];
         idle(HALF);
         rx[i] = spi_miso;
         oe_seen = oe_seen | spi_miso_oe;
         spi_sclk = 1;
         idle(HALF);
      end
      spi_cs_n = 1;
      idle(3 * HALF);
      cfg = (mode_a0 == 1'b1 && mode_a1 == 1'b0);
      if (cfg && nbits == 8) begin
         if (tx[7]) begin
            m_last = tx;
            if (tx == 8'hFF) m_armed = 1;
         end else if (m_last >= 0 && m_writable(m_last)) begin
            if (m_last == 'hF0) begin
               m_fault = 0; m_armed = 0; m_srst++;
            end else m_val[m_last] = int'(tx[6:0]);
         end else m_err = 1;
      end
      quiet = 1;
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] d;
      frame(b, 8, d);
   endtask

   task automatic wr(input logic [7:0] a, input logic [6:0] d);
      send(a);
      send({1'b0, d});
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
      logic [7:0] v;
      send(a);
      frame(8'hFF, 8, v);
      chk(tag, v, exp);
   endtask

   task automatic sample(input logic [7:0] f);
      fault_in = f;
      idle(4);
      sample_n = 0;
      idle(8);
      m_fault = m_armed ? f : (m_fault | f);
      m_armed = 0;
      sample_n = 1;
      idle(8);
   endtask

   initial begin
      do_reset();
      // R1 reset state at the outputs
      chk("R1 proto_err", proto_err_o, 0);
      chk("R1 res_sel", res_sel_o, 2);
      chk("R1 hyst/lock", {hyst_en_o, lock_range_o}, 2'b11);
      // R7 data before any address
      send(8'h15);
      chk("R7 proto_err", proto_err_o, 1);
      rd_chk("R7 ctrl untouched", 8'h92, 'h7E);
      rd_chk("R1 excit", 8'h91, 'h28);
      rd_chk("R1 thr", 8'h88, 'h00);
      rd_chk("R1 fault", 8'hFF, 'h00);

      do_reset();
      // R5 threshold row and excitation word
      for (int i = 0; i < 7; i++) wr(8'(8'h88 + i), 7'(8'h10 + 9 * i));
      for (int i = 0; i < 7; i++) rd_chk("R5 thr", 8'(8'h88 + i), 'h10 + 9 * i);
      wr(8'h91, 7'h3A);
      rd_chk("R5 excit", 8'h91, 'h3A);
      // R10 control fields
      wr(8'h92, 7'h21);
      chk("R10 res_sel", res_sel_o, 1);
      chk("R10 hyst/lock", {hyst_en_o, lock_range_o}, 2'b01);
      rd_chk("R10 ctrl", 8'h92, 'h21);
      wr(8'h92, 7'h13);
      chk("R10 res_sel b", res_sel_o, 3);
      chk("R10 hyst/lock b", {hyst_en_o, lock_range_o}, 2'b10);
      // R3 held address
      send(8'h8A); send(8'h05); send(8'h06);
      rd_chk("R3 repeated data", 8'h8A, 'h06);
      // R4 top bit cleared on 7-bit register
      wr(8'h89, 7'h7F);
      rd_chk("R4 seven-bit", 8'h89, 'h7F);
      // R6 unmapped reads and protected writes
      rd_chk("R6 hole", 8'h90, 0);
      rd_chk("R6 srst read", 8'hF0, 0);
      rd_chk("R6 high hole", 8'hA0, 0);
      chk("R6 no err on read", proto_err_o, 0);
      send(8'h90); send(8'h33);
      chk("R6 err set", proto_err_o, 1);
      rd_chk("R6 excit kept", 8'h91, 'h3A);
      send(8'h44);
      rd_chk("R6 fault not written", 8'hFF, 0);
      rd_chk("R6 ctrl kept", 8'h92, 'h13);
      // R2 non-config pin codes
      mode_a0 = 0; mode_a1 = 0; idle(8);
      send(8'h92);
      chk("R2 oe pos", oe_seen, 0);
      send(8'h00);
      mode_a1 = 1; idle(8);
      send(8'h92); send(8'h00);
      chk("R2 oe vel", oe_seen, 0);
      mode_a0 = 1; idle(8);
      send(8'h92); send(8'h00);
      chk("R2 oe rsv", oe_seen, 0);
      mode_a1 = 0; idle(8);
      rd_chk("R2 ctrl kept", 8'h92, 'h13);
      chk("R2 oe cfg", oe_seen, 1);
      // R11 partial frame
      wr(8'h8B, 7'h11);
      begin
         logic [7:0] d;
         frame(8'h8D, 4, d);
      end
      send(8'h22);
      rd_chk("R11 held addr", 8'h8B, 'h22);
      rd_chk("R11 other kept", 8'h8D, 'h3D);
      // R9 fault capture (last read armed it)
      sample(8'h01);
      sample(8'h04);
      rd_chk("R9 or-accumulate", 8'hFF, 'h05);
      sample(8'h80);
      sample(8'h20);
      rd_chk("R9 replace then or", 8'hFF, 'hA0);
      // R8 soft reset
      wr(8'hF0, 7'h00);
      chk("R8 pulse count", srst_cnt, 1);
      rd_chk("R8 fault cleared", 8'hFF, 0);
      rd_chk("R8 ctrl kept", 8'h92, 'h13);
      rd_chk("R8 thr kept", 8'h8B, 'h22);

      quiet = 0;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule